// File: doc/BRIEF.md
# Quad Screen-Space Derivative Unit

This block produces horizontal and vertical screen-space derivatives for every lane of a shader warp in a single registered step. The warp is split into independent groups of four lanes. Each group holds one 2x2 pixel block. Each lane's derivative comes from subtracting the operand value of a neighbouring lane in the same group. No memory is read, no other group is involved, and there is no wait state. The latency is always one cycle.

A lane that the triangle does not cover is a helper lane. It still provides its value to the subtractions that its group needs, so the covered lanes get correct derivatives. Its own results are then suppressed by a per-lane write-enable, which equals the coverage mask sampled with the input. A mode input chooses between per-row/per-column (fine) derivatives and a single per-group (coarse) pair. The mode is sampled together with the valid strobe.

Top module: `quad_deriv_unit`

## Requirements
- R1: Lane 4q+0 is top-left, 4q+1 top-right, 4q+2 bottom-left and 4q+3 bottom-right of group q; lane i occupies bits [16i+15:16i] of each packed vector. In fine mode (mode bit 0), lanes 4q+0 and 4q+1 get dx = v[4q+1]-v[4q+0], and lanes 4q+2 and 4q+3 get dx = v[4q+3]-v[4q+2].
- R2: In fine mode, lanes 4q+0 and 4q+2 get dy = v[4q+2]-v[4q+0], and lanes 4q+1 and 4q+3 get dy = v[4q+3]-v[4q+1].
- R3: In coarse mode (mode bit 1), all four lanes of group q get dx = v[4q+1]-v[4q+0] and dy = v[4q+2]-v[4q+0].
- R4: Values are 16-bit two's complement. A difference above 32767 gives 32767, and a difference below -32768 gives -32768.
- R5: outValid is high in exactly the cycle after a cycle with inValid high. The dx/dy results for that input appear in that same cycle.
- R6: During an outValid cycle, wrEn equals the coverage mask sampled with the input. wrEn is all zero whenever outValid is low.
- R7: An uncovered lane's value still feeds its group's derivatives. The dx/dy outputs of every lane are computed regardless of its coverage bit.
- R8: A lane's results depend only on the four values of its own group.
- R9: When inValid is low, dx/dy outputs hold their previous values. A mode or data change without valid has no effect.
- R10: After reset, outValid, wrEn, dxOut and dyOut are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Input operands valid this cycle |
| coarseMode | input | 1 | 0 = fine, 1 = coarse derivatives |
| inData | input | LANES*16 | Packed per-lane operand values |
| coverMask | input | LANES | Per-lane triangle coverage |
| outValid | output | 1 | Results valid this cycle |
| dxOut | output | LANES*16 | Packed per-lane horizontal derivatives |
| dyOut | output | LANES*16 | Packed per-lane vertical derivatives |
| wrEn | output | LANES | Per-lane result write-enable |

## Verification
The embedded properties are checked on every cycle. They cover the one-cycle valid timing, the write-enable that tracks the coverage mask and is zero when idle, the holding of results across idle cycles, and the sharing of one row or column difference between lanes, including full uniformity within a group in coarse mode. Only the bench scenarios show the arithmetic values themselves. These include the lane-to-pixel mapping, the subtraction direction, and clamping at both extremes. The bench also shows that helper lanes supply data to their group and that no group reads another group's lanes.

// File: rtl/quad_deriv_pkg.sv
package quad_deriv_pkg;
  typedef enum logic {
    MODE_FINE   = 1'b0,
    MODE_COARSE = 1'b1
  } deriv_mode_e;

  typedef struct packed {
    logic capture;
    logic coarse;
  } deriv_ctrl_t;
endpackage

// File: rtl/quad_deriv_ctrl.sv
module quad_deriv_ctrl
  import quad_deriv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        coarseMode,
  output deriv_ctrl_t ctrl,
  output logic        outValid
);
  deriv_mode_e modeSel;

  always_comb begin
    modeSel      = deriv_mode_e'(coarseMode);
    ctrl.capture = inValid;
    ctrl.coarse  = inValid && (modeSel == MODE_COARSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R5
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/quad_deriv_path.sv
module quad_deriv_path
  import quad_deriv_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  deriv_ctrl_t         ctrl,
  input  logic [LANES*DW-1:0] inData,
  input  logic [LANES-1:0]    coverMask,
  output logic [LANES*DW-1:0] dxOut,
  output logic [LANES*DW-1:0] dyOut,
  output logic [LANES-1:0]    wrEn
);
  localparam int QUADS = LANES / 4;
  localparam int QW    = 4 * DW;

  function automatic logic [DW-1:0] satSub(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] d;
    d = {a[DW-1], a} - {b[DW-1], b};
    if (d[DW] != d[DW-1])
      return d[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    return d[DW-1:0];
  endfunction

  for (genvar q = 0; q < QUADS; q++) begin : g_quad
    logic [DW-1:0] topLeft, topRight, botLeft, botRight;
    logic [DW-1:0] dxTop, dxBot, dyLeft, dyRight;
    logic [DW-1:0] dxNext [4];
    logic [DW-1:0] dyNext [4];
    logic [DW-1:0] dxReg  [4];
    logic [DW-1:0] dyReg  [4];

    assign topLeft  = inData[(4*q+0)*DW +: DW];
    assign topRight = inData[(4*q+1)*DW +: DW];
    assign botLeft  = inData[(4*q+2)*DW +: DW];
    assign botRight = inData[(4*q+3)*DW +: DW];

    always_comb begin
      dxTop   = satSub(topRight, topLeft);
      dxBot   = satSub(botRight, botLeft);
      dyLeft  = satSub(botLeft, topLeft);
      dyRight = satSub(botRight, topRight);
      dxNext[0] = dxTop;
      dxNext[1] = dxTop;
      dxNext[2] = ctrl.coarse ? dxTop : dxBot;
      dxNext[3] = ctrl.coarse ? dxTop : dxBot;
      dyNext[0] = dyLeft;
      dyNext[2] = dyLeft;
      dyNext[1] = ctrl.coarse ? dyLeft : dyRight;
      dyNext[3] = ctrl.coarse ? dyLeft : dyRight;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < 4; k++) begin
          dxReg[k] <= '0;
          dyReg[k] <= '0;
        end
      end else if (ctrl.capture) begin
        for (int k = 0; k < 4; k++) begin
          dxReg[k] <= dxNext[k];
          dyReg[k] <= dyNext[k];
        end
      end
    end

    for (genvar k = 0; k < 4; k++) begin : g_lane
      assign dxOut[(4*q+k)*DW +: DW] = dxReg[k];
      assign dyOut[(4*q+k)*DW +: DW] = dyReg[k];
    end

    // R3
    coarse_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.capture && ctrl.coarse |=>
        dxOut[4*q*DW +: QW] == {4{dxOut[4*q*DW +: DW]}} &&
        dyOut[4*q*DW +: QW] == {4{dyOut[4*q*DW +: DW]}});
    // R1
    fine_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.capture |=>
        dxOut[(4*q+0)*DW +: DW] == dxOut[(4*q+1)*DW +: DW] &&
        dxOut[(4*q+2)*DW +: DW] == dxOut[(4*q+3)*DW +: DW]);
    // R2
    fine_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.capture |=>
        dyOut[(4*q+0)*DW +: DW] == dyOut[(4*q+2)*DW +: DW] &&
        dyOut[(4*q+1)*DW +: DW] == dyOut[(4*q+3)*DW +: DW]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wrEn <= '0;
    else        wrEn <= ctrl.capture ? coverMask : '0;
  end

  // R6
  wren_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.capture |=> wrEn == $past(coverMask));
  // R6
  wren_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> wrEn == '0);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> $stable(dxOut) && $stable(dyOut));
endmodule

// File: rtl/quad_deriv_unit.sv
module quad_deriv_unit
  import quad_deriv_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic                coarseMode,
  input  logic [LANES*DW-1:0] inData,
  input  logic [LANES-1:0]    coverMask,
  output logic                outValid,
  output logic [LANES*DW-1:0] dxOut,
  output logic [LANES*DW-1:0] dyOut,
  output logic [LANES-1:0]    wrEn
);
  deriv_ctrl_t ctrl;

  quad_deriv_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .coarseMode (coarseMode),
    .ctrl       (ctrl),
    .outValid   (outValid)
  );

  quad_deriv_path #(.LANES(LANES), .DW(DW)) path_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .inData    (inData),
    .coverMask (coverMask),
    .dxOut     (dxOut),
    .dyOut     (dyOut),
    .wrEn      (wrEn)
  );

  initial begin
    lanes_quad_chk: assert (LANES % 4 == 0);
  end
endmodule

// File: tb/quad_deriv_unit_tb_top.sv
`timescale 1ns/1ps
module quad_deriv_unit_tb_top;
  localparam int LANES = 32;
  localparam int DW    = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                inValid = 1'b0;
  logic                coarseMode = 1'b0;
  logic [LANES*DW-1:0] inData = '0;
  logic [LANES-1:0]    coverMask = '0;
  logic                outValid;
  logic [LANES*DW-1:0] dxOut, dyOut;
  logic [LANES-1:0]    wrEn;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic signed [DW-1:0] vals [LANES];

  always #2 clk = ~clk;

  quad_deriv_unit #(.LANES(LANES), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .coarseMode(coarseMode),
    .inData(inData), .coverMask(coverMask), .outValid(outValid),
    .dxOut(dxOut), .dyOut(dyOut), .wrEn(wrEn)
  );

  function automatic logic [DW-1:0] clampDiff(input int a, input int b);
    int d = a - b;
    if (d > 32767)  d = 32767;
    if (d < -32768) d = -32768;
    return d[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] expDx(input int lane, input bit coarse);
    int b = (lane / 4) * 4;
    if (coarse || (lane % 4) < 2) return clampDiff(int'(vals[b+1]), int'(vals[b]));
    return clampDiff(int'(vals[b+3]), int'(vals[b+2]));
  endfunction

  function automatic logic [DW-1:0] expDy(input int lane, input bit coarse);
    int b = (lane / 4) * 4;
    if (coarse || (lane % 4) % 2 == 0) return clampDiff(int'(vals[b+2]), int'(vals[b]));
    return clampDiff(int'(vals[b+3]), int'(vals[b+1]));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic packVals();
    for (int i = 0; i < LANES; i++) inData[i*DW +: DW] = vals[i];
  endtask

  task automatic runTxn(input bit coarse, input logic [LANES-1:0] mask, input string tag);
    @(negedge clk);
    packVals();
    coarseMode = coarse;
    coverMask  = mask;
    inValid    = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid === 1'b1, {"R5 outValid ", tag}, outValid, 1);
    check(wrEn === mask, {"R6 wrEn ", tag}, wrEn, mask);
    for (int i = 0; i < LANES; i++) begin
      logic [DW-1:0] ex = expDx(i, coarse);
      logic [DW-1:0] ey = expDy(i, coarse);
      check(dxOut[i*DW +: DW] === ex, coarse ? {"R3 dx ", tag} : {"R1 dx ", tag}, dxOut[i*DW +: DW], ex);
      check(dyOut[i*DW +: DW] === ey, coarse ? {"R3 dy ", tag} : {"R2 dy ", tag}, dyOut[i*DW +: DW], ey);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(outValid === 1'b0, "R10 outValid", outValid, 0);
    check(wrEn === '0, "R10 wrEn", wrEn, 0);
    check(dxOut === '0 && dyOut === '0, "R10 dx/dy", dxOut[DW-1:0], 0);
    rst_n = 1'b1;

    // R1 R2 directed: distinct ramp pattern, fine mode, all covered
    for (int i = 0; i < LANES; i++) vals[i] = DW'(i * 37 - 500);
    runTxn(1'b0, '1, "ramp fine");
    // R3 directed coarse
    runTxn(1'b1, '1, "ramp coarse");

    // R4 saturation both directions
    for (int i = 0; i < LANES; i++) vals[i] = 16'sd0;
    vals[0] = -16'sd32768; vals[1] = 16'sd32767; vals[2] = 16'sd32767; vals[3] = -16'sd32768;
    vals[4] = 16'sd32767;  vals[5] = -16'sd32768; vals[6] = -16'sd32768; vals[7] = 16'sd32767;
    runTxn(1'b0, '1, "R4 sat fine");
    runTxn(1'b1, '1, "R4 sat coarse");

    // R7 helper lanes: one covered lane per quad, helpers carry data
    for (int i = 0; i < LANES; i++) vals[i] = DW'((i % 4) * 1000 + i);
    runTxn(1'b0, 32'h1111_1111, "R7 single lane");
    runTxn(1'b1, 32'h0000_0008, "R7 helper coarse");

    // R8 isolation: change other quads, quad 0 unaffected
    for (int i = 4; i < LANES; i++) vals[i] = 16'sh7fff;
    runTxn(1'b0, 32'h0000_000f, "R8 isolate");

    // R9 hold: idle cycle with changed data and mode
    begin
      logic [LANES*DW-1:0] keepDx, keepDy;
      keepDx = dxOut; keepDy = dyOut;
      for (int i = 0; i < LANES; i++) vals[i] = DW'($urandom);
      packVals();
      coarseMode = 1'b1;
      coverMask  = '1;
      @(negedge clk);
      check(dxOut === keepDx && dyOut === keepDy, "R9 hold", dxOut[DW-1:0], keepDx[DW-1:0]);
      check(outValid === 1'b0, "R5 idle outValid", outValid, 0);
      check(wrEn === '0, "R6 idle wrEn", wrEn, 0);
    end

    // random mix
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < LANES; i++) begin
        if ($urandom % 5 == 0) vals[i] = ($urandom % 2) ? 16'sh7fff : -16'sh8000;
        else vals[i] = DW'($urandom);
      end
      runTxn(1'($urandom), LANES'($urandom), "random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule